// File: doc/BRIEF.md
# Ethernet MAC Configuration Register Bank

This block holds the software-visible configuration of a tri-speed Ethernet MAC and turns it into decoded control signals for the MAC datapath. A management agent reaches it over a plain word-addressed bus: a single address, a write enable with 32-bit write data, and a read enable whose 32-bit result appears on the following cycle. The bank covers the receiver and transmitter control words, the 48-bit pause source address, flow-control and priority-pause enables, the link speed field, the two maximum-frame-length words and, when priority flow control is built in, eight per-priority quanta/refresh words and one legacy refresh word.

Each direction has a self-clearing reset command bit. Writing it returns only that direction's words to their defaults and emits a one-cycle strobe that the datapath uses to reset itself. The speed field keeps its value through these commands. Two build parameters pick the variant: `PFC_EN` decides whether the priority-pause registers and enable bits exist, and `GIG_ONLY` decides which speed codes may be written.

Top module: `emac_cfg_regbank`

## Requirements
- R1: After `rst_n` the receiver words read 0x400 = 0xFFFFFFFF, 0x404 = 0x1000FFFF (enable bit 28 set, bits 15:0 all ones) and 0x414 = 0x000007D0.
- R2: After `rst_n` the transmitter words read 0x408 = 0x10000000 and 0x418 = 0x000007D0, and the flow-control word 0x40C reads 0x6010FFFF with `PFC_EN`=1 and 0x60000000 with `PFC_EN`=0; with `PFC_EN`=0 only bits 30 and 29 of 0x40C are writable.
- R3: With `PFC_EN`=1 the words 0x480+4*i (i = 0..7) reset to 0xFF00FFFF (refresh in bits 31:16, quanta in 15:0) and 0x4A0 resets to 0xFF000000 with its lower half always 0; with `PFC_EN`=0 these addresses read 0 and ignore writes.
- R4: The speed code sits in 0x410[31:30] (00 = 10M, 01 = 100M, 10 = 1G) and resets to 10; with `GIG_ONLY`=1 it stays 10, with `GIG_ONLY`=0 a write is taken only when the code is 00 or 01 and otherwise ignored.
- R5: Reserved bits read 0 and ignore writes; addresses with no register, and any address whose two low bits are not zero, read 0 and ignore writes.
- R6: Writing 0x404 with bit 31 set restores 0x400, 0x404 and 0x414 to their defaults in the same cycle and discards the other bits of that write; bit 31 always reads 0; transmitter and flow-control words are unaffected.
- R7: Writing 0x408 with bit 31 set restores 0x408 and 0x418 to their defaults; bit 31 always reads 0; receiver and flow-control words are unaffected.
- R8: `rx_soft_rst` / `tx_soft_rst` is high for exactly the one cycle after a reset-command write and low otherwise.
- R9: Neither reset command changes the speed code.
- R10: `pause_sa` is {0x404[15:0], 0x400[31:0]}; the first address byte on the wire is `pause_sa[7:0]`.
- R11: `cfg_rdata` shows the addressed word on the cycle after `cfg_rd_en` is sampled high and holds it until the next read.
- R12: Decoded outputs follow the stored fields: 0x404 bits 30..24 = jumbo, FCS pass, enable, VLAN, half duplex, length/type check off, control length check off; 0x408 bits 30..25 = jumbo, FCS pass, enable, VLAN, half duplex, gap adjust; 0x40C bits 30, 29, 26, 25, 20 = pause TX, pause RX, PFC TX, PFC RX, auto-XON, bits 15:8 TX priority enables, 7:0 RX priority enables; max-length words bit 16 = enable, 14:0 = length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole bank |
| cfg_addr | input | ADDR_W | Byte address of the access |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_en | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Read data, one cycle after the strobe |
| pause_sa | output | 48 | Pause source MAC address |
| rx_enable | output | 1 | Receiver on |
| rx_jumbo | output | 1 | Receiver accepts oversize frames |
| rx_fcs_pass | output | 1 | Receiver forwards FCS to client |
| rx_vlan | output | 1 | Receiver accepts tagged frames |
| rx_half_duplex | output | 1 | Receiver half duplex |
| rx_lentype_chk_off | output | 1 | Length/type checks off |
| rx_ctlfrm_len_chk_off | output | 1 | Control frame length check off |
| rx_max_len_en | output | 1 | Receiver custom length limit on |
| rx_max_len | output | 15 | Receiver length limit |
| rx_soft_rst | output | 1 | One-cycle receiver reset strobe |
| tx_enable | output | 1 | Transmitter on |
| tx_jumbo | output | 1 | Transmitter sends oversize frames |
| tx_fcs_pass | output | 1 | Client supplies FCS |
| tx_vlan | output | 1 | Transmitter tagged frames |
| tx_half_duplex | output | 1 | Transmitter half duplex |
| tx_ifg_adj_en | output | 1 | Gap adjustment on |
| tx_max_len_en | output | 1 | Transmitter custom length limit on |
| tx_max_len | output | 15 | Transmitter length limit |
| tx_soft_rst | output | 1 | One-cycle transmitter reset strobe |
| pause_tx_en | output | 1 | Pause frame sending on |
| pause_rx_en | output | 1 | Pause frame honouring on |
| pfc_tx_en | output | 1 | Priority pause sending on |
| pfc_rx_en | output | 1 | Priority pause honouring on |
| auto_xon | output | 1 | Send zero-quanta frame on request drop |
| pfc_tx_prio_en | output | NUM_PRIO | Per-priority send enables |
| pfc_rx_prio_en | output | NUM_PRIO | Per-priority receive enables |
| prio_quanta | output | NUM_PRIO*16 | Quanta per priority, priority i at [16i+15:16i] |
| prio_refresh | output | NUM_PRIO*16 | Refresh interval per priority, same packing |
| pause_refresh | output | 16 | Legacy pause refresh interval |
| mac_speed | output | 2 | Speed code |

## Verification
A corrupt register shows up immediately on its decoded output pins and one cycle after any read of its address on `cfg_rdata`, so each scenario both reads back words and samples the decoded pins. A reset command that reaches the wrong direction, or misses part of its own, appears on the first read-back after the strobe: the bench reads all words of both directions and the speed word after each command. A strobe that lasts too long or fires at the wrong moment is caught by sampling both strobes on the cycle after the write and again one cycle later, and a broken variant choice shows as a differing read value between two instances built with opposite parameters.

// File: rtl/emac_cfg_pkg.sv
package emac_cfg_pkg;

   // byte addresses of the mapped words
   localparam int unsigned A_SA_LO   = 'h400;
   localparam int unsigned A_RX_CTL  = 'h404;
   localparam int unsigned A_TX_CTL  = 'h408;
   localparam int unsigned A_FC      = 'h40C;
   localparam int unsigned A_SPEED   = 'h410;
   localparam int unsigned A_RX_MAX  = 'h414;
   localparam int unsigned A_TX_MAX  = 'h418;
   localparam int unsigned A_Q_BASE  = 'h480;
   localparam int unsigned A_LEGACY  = 'h4A0;

   localparam int CMD_RST_BIT = 31;

   // defaults and writable masks
   localparam logic [31:0] SA_LO_DFLT   = 32'hFFFF_FFFF;
   localparam logic [31:0] RX_CTL_DFLT  = 32'h1000_FFFF;
   localparam logic [31:0] RX_CTL_MASK  = 32'h7F00_FFFF;
   localparam logic [31:0] TX_CTL_DFLT  = 32'h1000_0000;
   localparam logic [31:0] TX_CTL_MASK  = 32'h7E00_0000;
   localparam logic [31:0] MAX_DFLT     = 32'h0000_07D0;
   localparam logic [31:0] MAX_MASK     = 32'h0001_7FFF;
   localparam logic [31:0] FC_DFLT_PFC  = 32'h6010_FFFF;
   localparam logic [31:0] FC_MASK_PFC  = 32'h6610_FFFF;
   localparam logic [31:0] FC_DFLT_BASE = 32'h6000_0000;
   localparam logic [31:0] FC_MASK_BASE = 32'h6000_0000;
   localparam logic [31:0] PQ_DFLT      = 32'hFF00_FFFF;
   localparam logic [31:0] LEG_DFLT     = 32'hFF00_0000;
   localparam logic [31:0] LEG_MASK     = 32'hFFFF_0000;
   localparam logic [1:0]  SPD_1G       = 2'b10;

   function automatic logic [31:0] merge_wr(input logic [31:0] cur,
                                            input logic [31:0] nxt,
                                            input logic [31:0] msk);
      return (cur & ~msk) | (nxt & msk);
   endfunction

endpackage

// File: rtl/emac_cfg_rx.sv
module emac_cfg_rx
   import emac_cfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        sel_sa,
   input  logic        sel_ctl,
   input  logic        sel_max,
   input  logic [31:0] wdata,
   output logic [31:0] sa_lo_q,
   output logic [31:0] ctl_q,
   output logic [31:0] max_q,
   output logic        rst_pulse
);

   logic cmd_rst;
   assign cmd_rst = wr_en && sel_ctl && wdata[CMD_RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_lo_q   <= SA_LO_DFLT;
         ctl_q     <= RX_CTL_DFLT;
         max_q     <= MAX_DFLT;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= cmd_rst;
         if (cmd_rst) begin
            sa_lo_q <= SA_LO_DFLT;
            ctl_q   <= RX_CTL_DFLT;
            max_q   <= MAX_DFLT;
         end else if (wr_en) begin
            if (sel_sa)  sa_lo_q <= wdata;
            if (sel_ctl) ctl_q   <= merge_wr(ctl_q, wdata, RX_CTL_MASK);
            if (sel_max) max_q   <= merge_wr(max_q, wdata, MAX_MASK);
         end
      end
   end

   // R6: in the strobe cycle every receiver word holds its default
   p_rx_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> (sa_lo_q == SA_LO_DFLT && ctl_q == RX_CTL_DFLT && max_q == MAX_DFLT));

endmodule

// File: rtl/emac_cfg_tx.sv
module emac_cfg_tx
   import emac_cfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        sel_ctl,
   input  logic        sel_max,
   input  logic [31:0] wdata,
   output logic [31:0] ctl_q,
   output logic [31:0] max_q,
   output logic        rst_pulse
);

   logic cmd_rst;
   assign cmd_rst = wr_en && sel_ctl && wdata[CMD_RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= TX_CTL_DFLT;
         max_q     <= MAX_DFLT;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= cmd_rst;
         if (cmd_rst) begin
            ctl_q <= TX_CTL_DFLT;
            max_q <= MAX_DFLT;
         end else if (wr_en) begin
            if (sel_ctl) ctl_q <= merge_wr(ctl_q, wdata, TX_CTL_MASK);
            if (sel_max) max_q <= merge_wr(max_q, wdata, MAX_MASK);
         end
      end
   end

   // R7: in the strobe cycle both transmitter words hold their defaults
   p_tx_dflt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> (ctl_q == TX_CTL_DFLT && max_q == MAX_DFLT));

endmodule

// File: rtl/emac_cfg_fc.sv
module emac_cfg_fc
   import emac_cfg_pkg::*;
#(
   parameter bit PFC_EN   = 1'b1,
   parameter int NUM_PRIO = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                sel_fc,
   input  logic [NUM_PRIO-1:0] sel_pq,
   input  logic                sel_leg,
   input  logic [31:0]         wdata,
   output logic [31:0]         fc_q,
   output logic [31:0]         pq_q [NUM_PRIO],
   output logic [31:0]         leg_q
);

   localparam logic [31:0] FC_DFLT = PFC_EN ? FC_DFLT_PFC : FC_DFLT_BASE;
   localparam logic [31:0] FC_MASK = PFC_EN ? FC_MASK_PFC : FC_MASK_BASE;

   if (NUM_PRIO != 8) begin : g_bad_prio
      $error("emac_cfg_fc: enable fields are laid out for exactly 8 priorities");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 fc_q <= FC_DFLT;
      else if (wr_en && sel_fc)   fc_q <= merge_wr(fc_q, wdata, FC_MASK);
   end

   if (PFC_EN) begin : g_pfc
      for (genvar i = 0; i < NUM_PRIO; i++) begin : g_pq
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  pq_q[i] <= PQ_DFLT;
            else if (wr_en && sel_pq[i]) pq_q[i] <= wdata;
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                leg_q <= LEG_DFLT;
         else if (wr_en && sel_leg) leg_q <= merge_wr(leg_q, wdata, LEG_MASK);
      end
   end else begin : g_no_pfc
      for (genvar i = 0; i < NUM_PRIO; i++) begin : g_pq
         assign pq_q[i] = '0;
      end
      assign leg_q = '0;
   end

endmodule

// File: rtl/emac_cfg_speed.sv
module emac_cfg_speed
   import emac_cfg_pkg::*;
#(
   parameter bit GIG_ONLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       sel,
   input  logic [1:0] wcode,
   output logic [1:0] spd_q
);

   logic legal;

   if (GIG_ONLY) begin : g_gig
      assign legal = (wcode == SPD_1G);
      // R4: a gigabit build never leaves the 1G code
      p_spd_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
         spd_q == SPD_1G);
   end else begin : g_slow
      assign legal = !wcode[1];
      // R4: a 10/100 build never holds the undefined code
      p_spd_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
         spd_q != 2'b11);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      spd_q <= SPD_1G;
      else if (wr_en && sel && legal)  spd_q <= wcode;
   end

endmodule

// File: rtl/emac_cfg_regbank.sv
module emac_cfg_regbank
   import emac_cfg_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit PFC_EN   = 1'b1,
   parameter bit GIG_ONLY = 1'b1,
   parameter int NUM_PRIO = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      cfg_addr,
   input  logic                   cfg_wr_en,
   input  logic [31:0]            cfg_wdata,
   input  logic                   cfg_rd_en,
   output logic [31:0]            cfg_rdata,
   output logic [47:0]            pause_sa,
   output logic                   rx_enable,
   output logic                   rx_jumbo,
   output logic                   rx_fcs_pass,
   output logic                   rx_vlan,
   output logic                   rx_half_duplex,
   output logic                   rx_lentype_chk_off,
   output logic                   rx_ctlfrm_len_chk_off,
   output logic                   rx_max_len_en,
   output logic [14:0]            rx_max_len,
   output logic                   rx_soft_rst,
   output logic                   tx_enable,
   output logic                   tx_jumbo,
   output logic                   tx_fcs_pass,
   output logic                   tx_vlan,
   output logic                   tx_half_duplex,
   output logic                   tx_ifg_adj_en,
   output logic                   tx_max_len_en,
   output logic [14:0]            tx_max_len,
   output logic                   tx_soft_rst,
   output logic                   pause_tx_en,
   output logic                   pause_rx_en,
   output logic                   pfc_tx_en,
   output logic                   pfc_rx_en,
   output logic                   auto_xon,
   output logic [NUM_PRIO-1:0]    pfc_tx_prio_en,
   output logic [NUM_PRIO-1:0]    pfc_rx_prio_en,
   output logic [NUM_PRIO*16-1:0] prio_quanta,
   output logic [NUM_PRIO*16-1:0] prio_refresh,
   output logic [15:0]            pause_refresh,
   output logic [1:0]             mac_speed
);

   localparam int WA_W = ADDR_W - 2;

   if (ADDR_W < 12) begin : g_bad_addr
      $error("emac_cfg_regbank: ADDR_W must cover the 0x4FC map");
   end

   logic [WA_W-1:0] wa;
   logic            aligned;
   assign wa      = cfg_addr[ADDR_W-1:2];
   assign aligned = (cfg_addr[1:0] == 2'b00);

   logic sel_sa, sel_rx, sel_tx, sel_fc, sel_spd, sel_rxm, sel_txm, sel_leg;
   logic [NUM_PRIO-1:0] sel_pq;

   assign sel_sa  = aligned && (wa == WA_W'(A_SA_LO  >> 2));
   assign sel_rx  = aligned && (wa == WA_W'(A_RX_CTL >> 2));
   assign sel_tx  = aligned && (wa == WA_W'(A_TX_CTL >> 2));
   assign sel_fc  = aligned && (wa == WA_W'(A_FC     >> 2));
   assign sel_spd = aligned && (wa == WA_W'(A_SPEED  >> 2));
   assign sel_rxm = aligned && (wa == WA_W'(A_RX_MAX >> 2));
   assign sel_txm = aligned && (wa == WA_W'(A_TX_MAX >> 2));
   assign sel_leg = aligned && (wa == WA_W'(A_LEGACY >> 2));

   for (genvar i = 0; i < NUM_PRIO; i++) begin : g_pq_sel
      assign sel_pq[i] = aligned && (wa == WA_W'((A_Q_BASE >> 2) + i));
   end

   logic [31:0] sa_lo_q, rx_ctl_q, rx_max_q, tx_ctl_q, tx_max_q, fc_q, leg_q;
   logic [31:0] pq_q [NUM_PRIO];
   logic [1:0]  spd_q;

   emac_cfg_rx u_rx (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
      .sel_sa(sel_sa), .sel_ctl(sel_rx), .sel_max(sel_rxm), .wdata(cfg_wdata),
      .sa_lo_q(sa_lo_q), .ctl_q(rx_ctl_q), .max_q(rx_max_q), .rst_pulse(rx_soft_rst));

   emac_cfg_tx u_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
      .sel_ctl(sel_tx), .sel_max(sel_txm), .wdata(cfg_wdata),
      .ctl_q(tx_ctl_q), .max_q(tx_max_q), .rst_pulse(tx_soft_rst));

   emac_cfg_fc #(.PFC_EN(PFC_EN), .NUM_PRIO(NUM_PRIO)) u_fc (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
      .sel_fc(sel_fc), .sel_pq(sel_pq), .sel_leg(sel_leg), .wdata(cfg_wdata),
      .fc_q(fc_q), .pq_q(pq_q), .leg_q(leg_q));

   emac_cfg_speed #(.GIG_ONLY(GIG_ONLY)) u_spd (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .sel(sel_spd),
      .wcode(cfg_wdata[31:30]), .spd_q(spd_q));

   // read path
   logic [31:0] rd_val;
   logic        rd_hit;

   always_comb begin
      rd_val = '0;
      rd_hit = 1'b1;
      unique case (1'b1)
         sel_sa:  rd_val = sa_lo_q;
         sel_rx:  rd_val = rx_ctl_q;
         sel_tx:  rd_val = tx_ctl_q;
         sel_fc:  rd_val = fc_q;
         sel_spd: rd_val = {spd_q, 30'd0};
         sel_rxm: rd_val = rx_max_q;
         sel_txm: rd_val = tx_max_q;
         sel_leg: rd_val = leg_q;
         default: rd_hit = 1'b0;
      endcase
      for (int i = 0; i < NUM_PRIO; i++) begin
         if (sel_pq[i]) begin
            rd_val = pq_q[i];
            rd_hit = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_rdata <= '0;
      else if (cfg_rd_en) cfg_rdata <= rd_val;
   end

   // decoded outputs
   assign pause_sa              = {rx_ctl_q[15:0], sa_lo_q};
   assign rx_jumbo              = rx_ctl_q[30];
   assign rx_fcs_pass           = rx_ctl_q[29];
   assign rx_enable             = rx_ctl_q[28];
   assign rx_vlan               = rx_ctl_q[27];
   assign rx_half_duplex        = rx_ctl_q[26];
   assign rx_lentype_chk_off    = rx_ctl_q[25];
   assign rx_ctlfrm_len_chk_off = rx_ctl_q[24];
   assign rx_max_len_en         = rx_max_q[16];
   assign rx_max_len            = rx_max_q[14:0];
   assign tx_jumbo              = tx_ctl_q[30];
   assign tx_fcs_pass           = tx_ctl_q[29];
   assign tx_enable             = tx_ctl_q[28];
   assign tx_vlan               = tx_ctl_q[27];
   assign tx_half_duplex        = tx_ctl_q[26];
   assign tx_ifg_adj_en         = tx_ctl_q[25];
   assign tx_max_len_en         = tx_max_q[16];
   assign tx_max_len            = tx_max_q[14:0];
   assign pause_tx_en           = fc_q[30];
   assign pause_rx_en           = fc_q[29];
   assign pfc_tx_en             = fc_q[26];
   assign pfc_rx_en             = fc_q[25];
   assign auto_xon              = fc_q[20];
   assign pfc_tx_prio_en        = fc_q[15:8];
   assign pfc_rx_prio_en        = fc_q[7:0];
   assign pause_refresh         = leg_q[31:16];
   assign mac_speed             = spd_q;

   for (genvar i = 0; i < NUM_PRIO; i++) begin : g_pq_out
      assign prio_quanta[i*16 +: 16]  = pq_q[i][15:0];
      assign prio_refresh[i*16 +: 16] = pq_q[i][31:16];
   end

   // R5: a read of an unmapped address returns zero
   p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_en && !rd_hit) |=> (cfg_rdata == 32'd0));

   // R9: no reset strobe coincides with a speed change
   p_speed_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_soft_rst || tx_soft_rst) |-> $stable(mac_speed));

   // R11: a read captures the word present in its request cycle
   p_read_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_en && sel_spd && !cfg_wr_en) |=> (cfg_rdata[31:30] == $past(spd_q)));

endmodule

// File: tb/test_emac_cfg_regbank.sv
`timescale 1ns/1ps
module test_emac_cfg_regbank;

   localparam int AW = 32;
   localparam int NP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [AW-1:0] cfg_addr = '0;
   logic          cfg_wr_en = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic          cfg_rd_en = 1'b0;

   // main build: priority pause present, gigabit only
   logic [31:0] m_rdata;  logic [47:0] m_sa;
   logic m_rxen, m_rxj, m_rxf, m_rxv, m_rxh, m_rxl, m_rxc, m_rxme, m_rxrst;
   logic [14:0] m_rxml, m_txml;
   logic m_txen, m_txj, m_txf, m_txv, m_txh, m_txi, m_txme, m_txrst;
   logic m_ptx, m_prx, m_pfct, m_pfcr, m_axon;
   logic [NP-1:0] m_tpe, m_rpe;
   logic [NP*16-1:0] m_q, m_r;
   logic [15:0] m_leg;  logic [1:0] m_spd;

   // lite build: no priority pause, 10/100
   logic [31:0] l_rdata;  logic [47:0] l_sa;
   logic l_rxen, l_rxj, l_rxf, l_rxv, l_rxh, l_rxl, l_rxc, l_rxme, l_rxrst;
   logic [14:0] l_rxml, l_txml;
   logic l_txen, l_txj, l_txf, l_txv, l_txh, l_txi, l_txme, l_txrst;
   logic l_ptx, l_prx, l_pfct, l_pfcr, l_axon;
   logic [NP-1:0] l_tpe, l_rpe;
   logic [NP*16-1:0] l_q, l_r;
   logic [15:0] l_leg;  logic [1:0] l_spd;

   emac_cfg_regbank #(.ADDR_W(AW), .PFC_EN(1'b1), .GIG_ONLY(1'b1), .NUM_PRIO(NP)) i_emac_cfg_regbank (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
      .cfg_rd_en(cfg_rd_en), .cfg_rdata(m_rdata), .pause_sa(m_sa),
      .rx_enable(m_rxen), .rx_jumbo(m_rxj), .rx_fcs_pass(m_rxf), .rx_vlan(m_rxv),
      .rx_half_duplex(m_rxh), .rx_lentype_chk_off(m_rxl), .rx_ctlfrm_len_chk_off(m_rxc),
      .rx_max_len_en(m_rxme), .rx_max_len(m_rxml), .rx_soft_rst(m_rxrst),
      .tx_enable(m_txen), .tx_jumbo(m_txj), .tx_fcs_pass(m_txf), .tx_vlan(m_txv),
      .tx_half_duplex(m_txh), .tx_ifg_adj_en(m_txi), .tx_max_len_en(m_txme),
      .tx_max_len(m_txml), .tx_soft_rst(m_txrst),
      .pause_tx_en(m_ptx), .pause_rx_en(m_prx), .pfc_tx_en(m_pfct), .pfc_rx_en(m_pfcr),
      .auto_xon(m_axon), .pfc_tx_prio_en(m_tpe), .pfc_rx_prio_en(m_rpe),
      .prio_quanta(m_q), .prio_refresh(m_r), .pause_refresh(m_leg), .mac_speed(m_spd));

   emac_cfg_regbank #(.ADDR_W(AW), .PFC_EN(1'b0), .GIG_ONLY(1'b0), .NUM_PRIO(NP)) i_emac_cfg_regbank_lite (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
      .cfg_rd_en(cfg_rd_en), .cfg_rdata(l_rdata), .pause_sa(l_sa),
      .rx_enable(l_rxen), .rx_jumbo(l_rxj), .rx_fcs_pass(l_rxf), .rx_vlan(l_rxv),
      .rx_half_duplex(l_rxh), .rx_lentype_chk_off(l_rxl), .rx_ctlfrm_len_chk_off(l_rxc),
      .rx_max_len_en(l_rxme), .rx_max_len(l_rxml), .rx_soft_rst(l_rxrst),
      .tx_enable(l_txen), .tx_jumbo(l_txj), .tx_fcs_pass(l_txf), .tx_vlan(l_txv),
      .tx_half_duplex(l_txh), .tx_ifg_adj_en(l_txi), .tx_max_len_en(l_txme),
      .tx_max_len(l_txml), .tx_soft_rst(l_txrst),
      .pause_tx_en(l_ptx), .pause_rx_en(l_prx), .pfc_tx_en(l_pfct), .pfc_rx_en(l_pfcr),
      .auto_xon(l_axon), .pfc_tx_prio_en(l_tpe), .pfc_rx_prio_en(l_rpe),
      .prio_quanta(l_q), .prio_refresh(l_r), .pause_refresh(l_leg), .mac_speed(l_spd));

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [31:0] exp_m;
      logic [31:0] exp_l;
      string       tag;
   } rd_item_t;

   rd_item_t sb_q[$];

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   // driver: expectation goes into the scoreboard before the request
   task automatic rd(input logic [31:0] a, input logic [31:0] em, input logic [31:0] el, input string tag);
      rd_item_t it;
      it.exp_m = em; it.exp_l = el; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      cfg_addr = a; cfg_rd_en = 1'b1;
      @(negedge clk);
      cfg_rd_en = 1'b0;
   endtask

   // monitor: R11 read data is due on the cycle after the request
   logic rd_pend = 1'b0;
   always @(posedge clk) rd_pend <= cfg_rd_en;

   always @(negedge clk) begin
      if (rd_pend) begin
         if (sb_q.size() == 0) begin
            check(64'd1, 64'd0, "R11 unexpected read result");
         end else begin
            rd_item_t it;
            it = sb_q.pop_front();
            check({32'd0, m_rdata}, {32'd0, it.exp_m}, {it.tag, " main"});
            check({32'd0, l_rdata}, {32'd0, it.exp_l}, {it.tag, " lite"});
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R4 R12 reset state at the pins
      check(m_sa, 48'hFFFF_FFFF_FFFF, "R1 pause_sa reset");
      check({m_rxen, m_txen, m_rxj, m_txj}, 4'b1100, "R12 enables reset");
      check(m_spd, 2'b10, "R4 speed reset");
      check({l_axon, l_tpe, l_rpe}, 17'd0, "R2 lite priority enables");
      check({m_axon, m_tpe, m_rpe}, {1'b1, 16'hFFFF}, "R2 main priority enables");

      // R1 R2 R3 R4 reset read-back
      rd('h400, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 sa low");
      rd('h404, 32'h1000_FFFF, 32'h1000_FFFF, "R1 rx word");
      rd('h414, 32'h0000_07D0, 32'h0000_07D0, "R1 rx max");
      rd('h408, 32'h1000_0000, 32'h1000_0000, "R2 tx word");
      rd('h418, 32'h0000_07D0, 32'h0000_07D0, "R2 tx max");
      rd('h40C, 32'h6010_FFFF, 32'h6000_0000, "R2 fc word");
      rd('h410, 32'h8000_0000, 32'h8000_0000, "R4 speed word");
      rd('h480, 32'hFF00_FFFF, 32'h0, "R3 quanta p0");
      rd('h49C, 32'hFF00_FFFF, 32'h0, "R3 quanta p7");
      rd('h4A0, 32'hFF00_0000, 32'h0, "R3 legacy");

      // R10 R12 R5 receiver fields and address order
      wr('h404, 32'h6AFF_2211);
      wr('h400, 32'h6655_4433);
      check(m_sa, 48'h2211_6655_4433, "R10 pause_sa");
      check(m_sa[7:0], 8'h33, "R10 first byte");
      check({m_rxj, m_rxf, m_rxen, m_rxv, m_rxh, m_rxl, m_rxc}, 7'b1101010, "R12 rx fields");
      rd('h404, 32'h6A00_2211, 32'h6A00_2211, "R5 rx reserved bits");
      wr('h414, 32'hFFFF_FFFF);
      check({m_rxme, m_rxml}, {1'b1, 15'h7FFF}, "R12 rx max");
      rd('h414, 32'h0001_7FFF, 32'h0001_7FFF, "R5 rx max reserved");

      // transmitter fields
      wr('h408, 32'h7FFF_FFFF);
      check({m_txj, m_txf, m_txen, m_txv, m_txh, m_txi}, 6'b111111, "R12 tx fields");
      rd('h408, 32'h7E00_0000, 32'h7E00_0000, "R5 tx reserved");
      wr('h418, 32'h0001_0123);
      check({m_txme, m_txml}, {1'b1, 15'h0123}, "R12 tx max");

      // R4 speed legality
      wr('h410, 32'h0000_0000);
      rd('h410, 32'h8000_0000, 32'h0000_0000, "R4 speed 10M");
      wr('h410, 32'hC000_0000);
      rd('h410, 32'h8000_0000, 32'h0000_0000, "R4 speed code 11 ignored");
      wr('h410, 32'h8000_0000);
      rd('h410, 32'h8000_0000, 32'h0000_0000, "R4 speed 1G refused on 10/100");
      wr('h410, 32'h4000_0000);
      rd('h410, 32'h8000_0000, 32'h4000_0000, "R4 speed 100M");
      check({m_spd, l_spd}, 4'b1001, "R4 speed pins");

      // R5 reserved and unmapped
      wr('h41C, 32'hFFFF_FFFF);
      wr('h4F8, 32'hFFFF_FFFF);
      rd('h41C, 32'h0, 32'h0, "R5 reserved range");
      rd('h4F8, 32'h0, 32'h0, "R5 id slot");
      rd('h800, 32'h0, 32'h0, "R5 unmapped");
      wr('h402, 32'h0000_0000);
      rd('h400, 32'h6655_4433, 32'h6655_4433, "R5 misaligned write ignored");
      rd('h402, 32'h0, 32'h0, "R5 misaligned read");

      // R2 R12 flow control
      wr('h40C, 32'hFFFF_FFFF);
      rd('h40C, 32'h6610_FFFF, 32'h6000_0000, "R2 fc writable bits");
      wr('h40C, 32'h0000_0F0F);
      rd('h40C, 32'h0000_0F0F, 32'h0000_0000, "R2 fc pattern");
      check({m_ptx, m_prx, m_pfct, m_pfcr, m_axon, m_tpe, m_rpe}, {5'b0, 8'h0F, 8'h0F}, "R12 fc main");
      check({l_ptx, l_prx, l_rpe}, {2'b00, 8'h00}, "R12 fc lite");

      // R3 quanta and legacy refresh
      wr('h484, 32'h1234_5678);
      rd('h484, 32'h1234_5678, 32'h0, "R3 quanta p1");
      check(m_q[31:16], 16'h5678, "R3 quanta pin p1");
      check(m_r[31:16], 16'h1234, "R3 refresh pin p1");
      check(l_q, '0, "R3 lite quanta");
      wr('h4A0, 32'hABCD_EFFF);
      rd('h4A0, 32'hABCD_0000, 32'h0, "R3 legacy lower zero");
      check(m_leg, 16'hABCD, "R3 legacy pin");

      // R6 R8 R9 receiver reset command
      wr('h404, 32'h8000_0000);
      check({m_rxrst, m_txrst, l_rxrst}, 3'b101, "R8 rx strobe");
      @(negedge clk);
      check({m_rxrst, m_txrst, l_rxrst}, 3'b000, "R8 rx strobe width");
      rd('h400, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 sa low restored");
      rd('h404, 32'h1000_FFFF, 32'h1000_FFFF, "R6 rx word restored");
      rd('h414, 32'h0000_07D0, 32'h0000_07D0, "R6 rx max restored");
      rd('h408, 32'h7E00_0000, 32'h7E00_0000, "R6 tx untouched");
      rd('h418, 32'h0001_0123, 32'h0001_0123, "R6 tx max untouched");
      rd('h40C, 32'h0000_0F0F, 32'h0000_0000, "R6 fc untouched");
      rd('h410, 32'h8000_0000, 32'h4000_0000, "R9 speed after rx reset");

      // R7 R8 R9 transmitter reset command
      wr('h414, 32'h0000_0100);
      wr('h408, 32'hFFFF_FFFF);
      check({m_txrst, m_rxrst, l_txrst}, 3'b101, "R8 tx strobe");
      @(negedge clk);
      check({m_txrst, m_rxrst, l_txrst}, 3'b000, "R8 tx strobe width");
      rd('h408, 32'h1000_0000, 32'h1000_0000, "R7 tx word restored");
      rd('h418, 32'h0000_07D0, 32'h0000_07D0, "R7 tx max restored");
      rd('h414, 32'h0000_0100, 32'h0000_0100, "R7 rx untouched");
      rd('h410, 32'h8000_0000, 32'h4000_0000, "R9 speed after tx reset");
      check({m_txi, m_txen}, 2'b01, "R7 tx pins restored");

      repeat (4) @(negedge clk);
      check(sb_q.size(), 0, "R11 all reads answered");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule